// File: doc/BRIEF.md
# Voice Group Trigger Front End

This block sits between a host and the playback engine of a voice-playback controller. It turns host requests into a queue of voice-group addresses. A single 8-bit pin bus and a strobe pin are shared by two trigger modes, and a 2-bit mode input chooses between them.

In parallel mode the host places a binary group address on the bus and raises the strobe. The address is captured on the rising edge and queued. In serial mode three of the bus pins form a chip-select, clock and data link that carries command frames of one or two bytes. The commands can queue an address, stop and flush the queue, or choose which internal flag the status output reports.

The engine takes addresses from the head of the queue with a pop pulse and reports the end of playback with a done pulse. The block drives busy, full and a selectable status bit back to the host. Every pin input passes through a two-flop synchronizer before any edge is detected.

Top module: `vgt_front`

## Requirements
- R1: `mode_i` = 2'b01 selects parallel mode and 2'b10 selects serial mode. In modes 2'b00 and 2'b11, strobe and bus activity queue nothing and change no flag.
- R2: In parallel mode, a rising edge of `strobe_i` captures `sel_i` as a binary address (`sel_i[7]` is the MSB) and queues it. Code 0x00 is group 1 and code 0xFD is group 254. Queued addresses leave at `req_addr_o` in arrival order.
- R3: A parallel strobe that carries address 0xFE or 0xFF queues nothing.
- R4: Holding `strobe_i` high queues exactly one address. A repeat of that address needs a new rising edge. The strobe has no effect in serial mode.
- R5: In serial mode, `sel_i[0]` is an active-low chip select, `sel_i[1]` is the clock and `sel_i[2]` is the data input. A frame opens when the select falls. Bits are taken MSB first on each rising clock edge, and the frame closes when the select rises.
- R6: A frame that closes with any bit count other than 8 or 16 is discarded. A frame whose opcode is unknown, or whose length does not match its opcode, has no effect.
- R7: The opcode is `cmd[3:0]`. Opcode 1 in a 16-bit frame queues the second byte as an address, and 0xFE and 0xFF are rejected as in R3.
- R8: Opcode 2 in an 8-bit frame empties the queue and clears both busy and the overflow flag.
- R9: Opcode 3 in an 8-bit frame sets the source of `stat_o` from `cmd[5:4]`. The codes are: 0 = overflow flag, 1 = queue not empty, 2 = queue full, 3 = busy. After reset the source is the overflow flag.
- R10: The queue holds 4 addresses. `full_o` is high while it holds 4. A request that arrives while the queue is full is dropped and sets a sticky overflow flag.
- R11: `busy_o` rises after a `pop_i` that finds the queue not empty, and falls after `done_i`. When a valid pop and a done occur in the same cycle, busy stays high.
- R12: After reset the queue is empty, and `req_valid_o`, `full_o`, `busy_o` and `stat_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | Trigger mode select |
| sel_i | input | 8 | Shared pin bus: address in parallel mode; select, clock and data in serial mode |
| strobe_i | input | 1 | Parallel address strobe |
| pop_i | input | 1 | Engine takes the head address |
| done_i | input | 1 | Engine finished playback |
| req_valid_o | output | 1 | Queue holds at least one address |
| req_addr_o | output | 8 | Address at the head of the queue |
| busy_o | output | 1 | Playback in progress |
| full_o | output | 1 | Queue has no free entry |
| stat_o | output | 1 | Host-selected status flag |

## Verification
Parallel strobes use random valid addresses mixed with the two reserved codes. This shows whether address capture, bit order and the validity screen are right. Serial frames come in five kinds: play, stop, select and unknown-opcode commands, plus frames of random wrong length. Together they show whether the receiver counts bits and decodes the opcode against the frame length. Directed cases then cover a held strobe, a strobe in the wrong mode, the two unused modes, filling the queue past full, opcodes sent with the wrong length, and a pop and done in the same cycle, so that queue overflow and busy priority are each seen on their own.

// File: rtl/vgt_pkg.sv
package vgt_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] OP_PLAY = 4'h1;
    localparam logic [3:0] OP_STOP = 4'h2;
    localparam logic [3:0] OP_SEL  = 4'h3;
    localparam logic [7:0] LAST_GROUP = 8'hFD;

    typedef enum logic [1:0] {
        FLG_OVF   = 2'd0,
        FLG_AVAIL = 2'd1,
        FLG_FULL  = 2'd2,
        FLG_BUSY  = 2'd3
    } flag_sel_e;

    function automatic logic addr_ok(input logic [7:0] a);
        return a <= LAST_GROUP;
    endfunction
endpackage

// File: rtl/vgt_sync.sv
module vgt_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, meta_d, hold_q, hold_d;

    always_comb begin
        meta_d = async_i;
        hold_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= meta_d;
            hold_q <= hold_d;
        end
    end

    assign sync_o = hold_q;
endmodule

// File: rtl/vgt_serial_rx.sv
module vgt_serial_rx #(
    parameter int FRAME_W = 16,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              frame_valid_o,
    output logic              frame_long_o,
    output logic [BYTE_W-1:0] cmd_o,
    output logic [BYTE_W-1:0] arg_o
);
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic               active;
        logic               cs_prev;
        logic               sck_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
    } rx_t;

    rx_t q, d;
    logic cs_fall, cs_rise, sck_rise;

    always_comb begin
        d        = q;
        d.cs_prev  = cs_n_i;
        d.sck_prev = sck_i;
        cs_fall  = q.cs_prev & ~cs_n_i;
        cs_rise  = ~q.cs_prev & cs_n_i;
        sck_rise = ~q.sck_prev & sck_i;
        frame_valid_o = 1'b0;
        if (!enable_i) begin
            d.active = 1'b0;
        end else if (cs_fall) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.shreg  = '0;
        end else if (q.active && cs_rise) begin
            d.active      = 1'b0;
            frame_valid_o = (q.cnt == CNT_W'(BYTE_W)) || (q.cnt == CNT_W'(FRAME_W));
        end else if (q.active && sck_rise && !cs_n_i) begin
            d.shreg = {q.shreg[FRAME_W-2:0], sdi_i};
            if (q.cnt != CNT_W'(CNT_MAX)) d.cnt = q.cnt + 1'b1;
        end
        frame_long_o = (q.cnt == CNT_W'(FRAME_W));
        cmd_o = frame_long_o ? q.shreg[FRAME_W-1 -: BYTE_W] : q.shreg[BYTE_W-1:0];
        arg_o = q.shreg[BYTE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: the bit counter saturates just above the longest frame
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(CNT_MAX));
    // R1: no frame completes outside serial mode
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !q.active);
endmodule

// File: rtl/vgt_fifo.sv
module vgt_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic                       flush_i,
    input  logic [W-1:0]               data_i,
    output logic [W-1:0]               data_o,
    output logic                       full_o,
    output logic                       empty_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [LVL_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, d;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        do_push = push_i && (q.cnt != LVL_W'(DEPTH));
        do_pop  = pop_i && (q.cnt != '0);
        if (flush_i) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wr] = data_i;
                d.wr        = bump(q.wr);
            end
            if (do_pop) d.rd = bump(q.rd);
            if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
            else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o  = q.mem[q.rd];
    assign full_o  = (q.cnt == LVL_W'(DEPTH));
    assign empty_o = (q.cnt == '0);
    assign level_o = q.cnt;

    // R10: the occupancy never passes the depth
    p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LVL_W'(DEPTH));
    // R10: a push into a full queue leaves it full, not larger
    p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && push_i && !pop_i && !flush_i |=> full_o);
endmodule

// File: rtl/vgt_front.sv
module vgt_front #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] sel_i,
    input  logic              strobe_i,
    input  logic              pop_i,
    input  logic              done_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic              busy_o,
    output logic              full_o,
    output logic              stat_o
);
    import vgt_pkg::*;

    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int PINS_W = ADDR_W + 1;

    typedef struct packed {
        logic      ovf;
        logic      busy;
        flag_sel_e psel;
        logic      stb_prev;
    } ctl_t;

    ctl_t q, d;

    logic [PINS_W-1:0] pins_s;
    logic [ADDR_W-1:0] addr_s, cmd, arg, cand;
    logic              strobe_s, par_mode, ser_mode, strobe_rise;
    logic              fv, flong, play_cmd, stop_cmd, sel_cmd, par_req;
    logic              cand_valid, push, drop, pop_ok, empty;
    logic [LVL_W-1:0]  level;

    vgt_sync #(.W(PINS_W)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({strobe_i, sel_i}),
        .sync_o(pins_s)
    );

    assign strobe_s = pins_s[ADDR_W];
    assign addr_s   = pins_s[ADDR_W-1:0];
    assign par_mode = (mode_i == 2'b01);
    assign ser_mode = (mode_i == 2'b10);

    vgt_serial_rx #(.FRAME_W(2*ADDR_W), .BYTE_W(ADDR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable_i(ser_mode),
        .cs_n_i(addr_s[0]), .sck_i(addr_s[1]), .sdi_i(addr_s[2]),
        .frame_valid_o(fv), .frame_long_o(flong),
        .cmd_o(cmd), .arg_o(arg)
    );

    vgt_fifo #(.DEPTH(DEPTH), .W(ADDR_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .pop_i(pop_ok), .flush_i(stop_cmd),
        .data_i(cand), .data_o(req_addr_o),
        .full_o(full_o), .empty_o(empty), .level_o(level)
    );

    always_comb begin
        d          = q;
        d.stb_prev = strobe_s;
        strobe_rise = strobe_s & ~q.stb_prev;
        par_req    = par_mode & strobe_rise;
        play_cmd   = fv &  flong & (cmd[3:0] == OP_PLAY);
        stop_cmd   = fv & ~flong & (cmd[3:0] == OP_STOP);
        sel_cmd    = fv & ~flong & (cmd[3:0] == OP_SEL);
        cand       = par_req ? addr_s : arg;
        cand_valid = (par_req | play_cmd) & addr_ok(cand);
        push       = cand_valid & ~full_o;
        drop       = cand_valid &  full_o;
        pop_ok     = pop_i & ~empty & ~stop_cmd;

        d.ovf = stop_cmd ? 1'b0 : (q.ovf | drop);
        if (stop_cmd)    d.busy = 1'b0;
        else if (pop_ok) d.busy = 1'b1;
        else if (done_i) d.busy = 1'b0;
        if (sel_cmd) d.psel = flag_sel_e'(cmd[5:4]);

        unique case (q.psel)
            FLG_OVF:   stat_o = q.ovf;
            FLG_AVAIL: stat_o = ~empty;
            FLG_FULL:  stat_o = full_o;
            default:   stat_o = q.busy;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_valid_o = ~empty;
    assign busy_o      = q.busy;

    // R3: a reserved code on the strobe does not grow the queue
    p_bad_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        par_req && !addr_ok(addr_s) && !pop_ok |=> level == $past(level));
    // R1: unused modes never add entries
    p_mode_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !par_mode && !ser_mode && !pop_i |=> level <= $past(level));
    // R11: a pop of a valid entry starts playback
    p_busy_on_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && req_valid_o && !stop_cmd |=> busy_o);
    // R11: done without a pop ends playback
    p_done_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && !pop_i |=> !busy_o);
    // R10: a dropped request marks overflow
    p_drop_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid && full_o && !stop_cmd |=> q.ovf);
    // R8: stop leaves an empty, idle queue
    p_stop_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !req_valid_o && !busy_o && !q.ovf);
endmodule

// File: tb/vgt_front_tb.sv
module vgt_front_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [7:0] sel_i = 8'h01;
    logic       strobe_i = 1'b0;
    logic       pop_i = 1'b0;
    logic       done_i = 1'b0;
    logic       req_valid_o, busy_o, full_o, stat_o;
    logic [7:0] req_addr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int unsigned mq[$];
    bit m_ovf = 0, m_busy = 0;
    int m_psel = 0;

    always #4 clk = ~clk;

    vgt_front u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sel_i(sel_i),
        .strobe_i(strobe_i), .pop_i(pop_i), .done_i(done_i),
        .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
        .busy_o(busy_o), .full_o(full_o), .stat_o(stat_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit m_stat();
        case (m_psel)
            0: return m_ovf;
            1: return mq.size() > 0;
            2: return mq.size() == 4;
            default: return m_busy;
        endcase
    endfunction

    function automatic bit valid_addr(input int unsigned a);
        return a <= 32'hFD;
    endfunction

    task automatic m_push(input int unsigned a);
        if (!valid_addr(a)) return;
        if (mq.size() == 4) m_ovf = 1;
        else mq.push_back(a);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        wait_n(6);
        check({tag, " valid"}, req_valid_o, mq.size() > 0);
        check({tag, " full"}, full_o, mq.size() == 4);
        check({tag, " busy"}, busy_o, m_busy);
        check({tag, " stat"}, stat_o, m_stat());
        if (mq.size() > 0) check({tag, " head"}, req_addr_o, mq[0]);
    endtask

    task automatic par_strobe(input logic [7:0] a);
        mode_i = 2'b01;
        sel_i = a;
        wait_n(4);
        strobe_i = 1'b1;
        wait_n(4);
        strobe_i = 1'b0;
        wait_n(4);
    endtask

    task automatic ser_frame(input logic [15:0] bits, input int nb);
        mode_i = 2'b10;
        sel_i = 8'h01;
        wait_n(4);
        sel_i[0] = 1'b0;
        wait_n(4);
        for (int i = nb - 1; i >= 0; i--) begin
            sel_i[2] = (i < 16) ? bits[i] : 1'b0;
            sel_i[1] = 1'b0;
            wait_n(3);
            sel_i[1] = 1'b1;
            wait_n(3);
        end
        sel_i[1] = 1'b0;
        wait_n(3);
        sel_i[0] = 1'b1;
        wait_n(6);
    endtask

    task automatic do_pop();
        pop_i = 1'b1;
        wait_n(1);
        pop_i = 1'b0;
        if (mq.size() > 0) begin
            void'(mq.pop_front());
            m_busy = 1;
        end
    endtask

    task automatic do_done();
        done_i = 1'b1;
        wait_n(1);
        done_i = 1'b0;
        m_busy = 0;
    endtask

    task automatic ser_play(input logic [7:0] a);
        ser_frame({8'h01, a}, 16);
        m_push(a);
    endtask

    task automatic ser_stop();
        ser_frame({8'h00, 8'h02}, 8);
        mq.delete();
        m_busy = 0;
        m_ovf = 0;
    endtask

    task automatic ser_sel(input int f);
        ser_frame({8'h00, 2'b00, 2'(f), 4'h3}, 8);
        m_psel = f;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        wait_n(3);
        check("R12 reset valid", req_valid_o, 0);
        check("R12 reset full", full_o, 0);
        check("R12 reset busy", busy_o, 0);
        check("R12 reset stat", stat_o, 0);
        rst_n = 1'b1;
        wait_n(3);
        check_all("R12 after reset");

        // R2 boundary codes and bit order
        par_strobe(8'h00); m_push(8'h00);
        par_strobe(8'hFD); m_push(8'hFD);
        par_strobe(8'h88); m_push(8'h88);
        check_all("R2 parallel capture");
        // R3 reserved codes
        par_strobe(8'hFE);
        par_strobe(8'hFF);
        check_all("R3 reserved ignored");
        // R11 pop then done, and both together
        do_pop();
        check_all("R11 pop sets busy");
        do_done();
        check_all("R11 done clears busy");
        do_pop();
        pop_i = 1'b1; done_i = 1'b1;
        wait_n(1);
        pop_i = 1'b0; done_i = 1'b0;
        void'(mq.pop_front()); m_busy = 1;
        check_all("R11 pop with done");
        do_done();
        // R4 held strobe queues once
        mode_i = 2'b01; sel_i = 8'h12;
        wait_n(4);
        strobe_i = 1'b1;
        wait_n(40);
        m_push(8'h12);
        check_all("R4 held strobe");
        strobe_i = 1'b0;
        wait_n(4);
        // R4 strobe in serial mode, R1 unused modes
        mode_i = 2'b10; sel_i = 8'h01;
        wait_n(4);
        strobe_i = 1'b1; wait_n(4); strobe_i = 1'b0; wait_n(4);
        check_all("R4 strobe in serial mode");
        for (int m = 0; m < 4; m += 3) begin
            mode_i = 2'(m); sel_i = 8'h20;
            wait_n(4);
            strobe_i = 1'b1; wait_n(4); strobe_i = 1'b0; wait_n(4);
            sel_i = 8'h00; wait_n(4); sel_i = 8'h07; wait_n(4);
            check_all("R1 unused mode");
        end
        // R5 R7 serial play, R10 fill past full
        ser_play(8'h3C);
        check_all("R5 R7 serial play");
        ser_play(8'hFE);
        check_all("R7 reserved via serial");
        ser_play(8'h41); ser_play(8'h42);
        check_all("R10 queue full");
        ser_play(8'h43);
        par_strobe(8'h44); m_push(8'h44);
        check_all("R10 overflow drop");
        // R9 each flag selection
        for (int f = 0; f < 4; f++) begin
            ser_sel(f);
            check_all("R9 status select");
        end
        // R6 wrong lengths and mismatched opcodes
        ser_frame(16'h00A5, 7);
        ser_frame(16'hFFFF, 9);
        ser_frame(16'h0000, 0);
        ser_frame({8'h00, 8'h02}, 17);
        check_all("R6 bad length");
        ser_frame({8'h02, 8'h00}, 16);
        ser_frame({8'h00, 8'h01}, 8);
        ser_frame({8'h00, 8'h0C}, 8);
        check_all("R6 opcode length mismatch");
        // R8 stop
        ser_sel(0);
        do_pop();
        ser_stop();
        check_all("R8 stop flush");

        // randomized mix
        for (int it = 0; it < 120; it++) begin
            int op;
            logic [7:0] a;
            op = int'($urandom_range(0, 7));
            a = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 5) == 0) a = 8'hFE | 8'($urandom_range(0, 1));
            case (op)
                0: begin par_strobe(a); m_push(a); check_all("R2 random strobe"); end
                1: begin ser_play(a); check_all("R7 random play"); end
                2: begin do_pop(); check_all("R11 random pop"); end
                3: begin do_done(); check_all("R11 random done"); end
                4: if ($urandom_range(0, 3) == 0) begin ser_stop(); check_all("R8 random stop"); end
                5: begin ser_sel(int'($urandom_range(0, 3))); check_all("R9 random select"); end
                6: begin
                    int nb;
                    nb = int'($urandom_range(0, 20));
                    if (nb == 8 || nb == 16) nb = nb + 1;
                    ser_frame(16'($urandom), nb);
                    check_all("R6 random bad length");
                end
                default: begin
                    ser_frame({8'h00, 2'b00, 2'($urandom_range(0, 3)), 4'h0 | 4'($urandom_range(4, 15))}, 8);
                    check_all("R6 random unknown opcode");
                end
            endcase
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule